// File: doc/BRIEF.md
# Event-Flag Serial Port Register Interface

This block is the software-visible side of a simple serial port. A processor reaches it through five word-addressed 32-bit registers. On the line side it has a byte transmit stream and a byte receive stream, each using valid/ready. The bit-serial engine is outside this block and connects to those two streams.

Writing the data register hands one byte to the transmit stream and latches a transmit event. An inbound byte is taken only while the receive event is clear. Taking it stores the byte and latches the receive event, so the receive path holds at most one byte. Software clears either event by writing a 1 to its bit in the flag register. The single level interrupt is the OR of each latched event gated by its own enable bit.

The baud divisor, the configuration word and the diagnostic word are plain storage. Only the two interrupt-enable bits of the configuration word act inside the block.

Top module: `uart_evt_regif`

Register offsets (word address): 0 DATA, 1 BAUD, 2 FLAGS, 3 CFG, 4 DIAG.
FLAGS bits: bit 0 is transmit-free and always reads 1, bit 1 is RXHIT, bit 2 is TXHIT.
CFG bits: bit 0 is the receive interrupt enable, bit 1 is the transmit interrupt enable, bit 2 is the pass-through mode bit (stored only).
DIAG bit 0 is the break enable (stored only).

## Requirements
- R1: After reset every register reads 0, except FLAGS, which reads 0x1. After reset `irq` and `tx_valid` are 0 and `rx_ready` is 1.
- R2: A full 32-bit value written to BAUD (offset 1), CFG (offset 3) or DIAG (offset 4) reads back unchanged at the same offset.
- R3: A write to offset 0 puts `bus_wdata[7:0]` on `tx_data` with `tx_valid` high from the next cycle. `tx_valid` and `tx_data` then hold until a cycle with `tx_ready` high. A write to offset 0 made while a byte is still pending replaces that byte.
- R4: A write to offset 0 sets TXHIT (FLAGS bit 2) from the next cycle.
- R5: `rx_ready` equals the inverse of RXHIT. When `rx_valid` and `rx_ready` are both high at a clock edge, the byte reads back zero-extended at offset 0 and RXHIT (FLAGS bit 1) is set from the next cycle.
- R6: While RXHIT is set, bytes offered on `rx_valid` are not taken, and the offset-0 readback keeps the earlier byte.
- R7: A write to offset 2 clears RXHIT when bit 1 of the written data is 1 and clears TXHIT when bit 2 is 1. It leaves all other flag state unchanged, and FLAGS bit 0 always reads 1.
- R8: Reading offset 0 clears no flag.
- R9: `irq` is high exactly when (RXHIT and CFG bit 0) or (TXHIT and CFG bit 1). It follows every register write and every taken byte one cycle after the edge.
- R10: Writes to offsets 5 and above change no register. Reads of those offsets return 0.
- R11: `bus_rdata` is 0 in any cycle that is not a read access (`bus_sel` low, or `bus_wr` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (3) | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, same cycle |
| tx_valid | output | 1 | Transmit byte pending |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Line engine takes the transmit byte |
| rx_valid | input | 1 | Inbound byte offered |
| rx_data | input | 8 | Inbound byte |
| rx_ready | output | 1 | Block can take an inbound byte |
| irq | output | 1 | Level interrupt |

## Verification
The interrupt is swept over all sixteen combinations of the two latched events and the two enables. Each combination also checks the FLAGS readback, which shows whether the events and their enables are decoded to the right bits.

The storage registers get walking-one and walking-zero patterns, which reveal stuck or crossed bits. The flag-clear write is tried with each one-hot and combined mask, which shows whether each clear bit acts only on its own event.

Receive back-pressure is tested by offering a second byte while the first is unread. The transmit hold is tested by keeping `tx_ready` low across a replacement write. Out-of-range offsets are written with all-ones, then every real register is read back to confirm nothing changed.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
    localparam int REG_W    = 32;
    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 5;
    localparam int IDX_W    = 3;
    localparam int NUM_EVT  = 2;

    // Flag and enable bit positions, decoded by software
    localparam int FLG_TXFREE = 0;
    localparam int FLG_RXHIT  = 1;
    localparam int FLG_TXHIT  = 2;
    localparam int CFG_RXIE   = 0;
    localparam int CFG_TXIE   = 1;

    typedef enum logic [IDX_W-1:0] {
        REG_DATA  = 3'd0,
        REG_BAUD  = 3'd1,
        REG_FLAGS = 3'd2,
        REG_CFG   = 3'd3,
        REG_DIAG  = 3'd4
    } reg_e;

    typedef struct packed {
        logic [BYTE_W-1:0] rx_byte;
        logic [BYTE_W-1:0] tx_byte;
        logic              tx_pend;
        logic              rx_evt;
        logic              tx_evt;
        logic [REG_W-1:0]  baud;
        logic [REG_W-1:0]  cfg;
        logic [REG_W-1:0]  diag;
    } core_st_t;
endpackage

// File: rtl/uart_evt_decode.sv
module uart_evt_decode
    import uart_evt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic              rd_en,
    output reg_e              idx
);
    logic hit;

    always_comb begin
        hit   = (addr < ADDR_W'(NUM_REGS));
        wr_en = sel && wr && hit;
        rd_en = sel && !wr && hit;
        idx   = reg_e'(addr[IDX_W-1:0]);
    end
endmodule

// File: rtl/uart_evt_irq.sv
module uart_evt_irq #(
    parameter int N = 2
) (
    input  logic [N-1:0] evt,
    input  logic [N-1:0] en,
    output logic         irq
);
    logic [N-1:0] gated;

    for (genvar g = 0; g < N; g++) begin : g_gate
        assign gated[g] = evt[g] & en[g];
    end

    assign irq = |gated;
endmodule

// File: rtl/uart_evt_core.sv
module uart_evt_core
    import uart_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  reg_e              idx,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic [NUM_EVT-1:0] evt,
    output logic [NUM_EVT-1:0] evt_en
);
    core_st_t st_d, st_q;
    logic     take_d;

    always_comb begin
        st_d   = st_q;
        take_d = rx_valid && !st_q.rx_evt;
        if (st_q.tx_pend && tx_ready) begin
            st_d.tx_pend = 1'b0;
        end
        if (wr_en) begin
            case (idx)
                REG_DATA: begin
                    st_d.tx_byte = wdata[BYTE_W-1:0];
                    st_d.tx_pend = 1'b1;
                    st_d.tx_evt  = 1'b1;
                end
                REG_BAUD:  st_d.baud = wdata;
                REG_FLAGS: begin
                    if (wdata[FLG_RXHIT]) st_d.rx_evt = 1'b0;
                    if (wdata[FLG_TXHIT]) st_d.tx_evt = 1'b0;
                end
                REG_CFG:   st_d.cfg  = wdata;
                REG_DIAG:  st_d.diag = wdata;
                default: ;
            endcase
        end
        if (take_d) begin
            st_d.rx_byte = rx_data;
            st_d.rx_evt  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (idx)
                REG_DATA:  rdata = {{(REG_W-BYTE_W){1'b0}}, st_q.rx_byte};
                REG_BAUD:  rdata = st_q.baud;
                REG_FLAGS: begin
                    rdata[FLG_TXFREE] = 1'b1;
                    rdata[FLG_RXHIT]  = st_q.rx_evt;
                    rdata[FLG_TXHIT]  = st_q.tx_evt;
                end
                REG_CFG:   rdata = st_q.cfg;
                REG_DIAG:  rdata = st_q.diag;
                default:   rdata = '0;
            endcase
        end
    end

    assign tx_valid = st_q.tx_pend;
    assign tx_data  = st_q.tx_byte;
    assign rx_ready = !st_q.rx_evt;
    assign evt      = {st_q.tx_evt, st_q.rx_evt};
    assign evt_en   = {st_q.cfg[CFG_TXIE], st_q.cfg[CFG_RXIE]};

    p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !(wr_en && idx == REG_DATA))
        |=> (tx_valid && $stable(tx_data)));

    p_tx_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == REG_DATA) |=> evt[1]);

    p_rx_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> (!rx_ready && st_q.rx_byte == $past(rx_data)));

    p_rx_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && !(wr_en && idx == REG_FLAGS && wdata[FLG_RXHIT]))
        |=> (!rx_ready && $stable(st_q.rx_byte)));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == REG_FLAGS && wdata[FLG_TXHIT]) |=> !evt[1]);

    p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(st_q.baud) && $stable(st_q.cfg) && $stable(st_q.diag)));
endmodule

// File: rtl/uart_evt_regif.sv
module uart_evt_regif
    import uart_evt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              irq
);
    logic               wr_en, rd_en;
    reg_e               idx;
    logic [NUM_EVT-1:0] evt, evt_en;

    uart_evt_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .wr_en(wr_en), .rd_en(rd_en), .idx(idx)
    );

    uart_evt_core u_core (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .rd_en(rd_en), .idx(idx),
        .wdata(bus_wdata), .rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .evt(evt), .evt_en(evt_en)
    );

    uart_evt_irq #(.N(NUM_EVT)) u_irq (
        .evt(evt), .en(evt_en), .irq(irq)
    );

    p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel || bus_wr) |-> (bus_rdata == '0));

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0) |-> !irq);
endmodule

// File: tb/tb_uart_evt_regif.sv
module tb_uart_evt_regif;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [2:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        tx_valid, tx_ready = 1;
    logic [7:0]  tx_data;
    logic        rx_valid = 0, rx_ready;
    logic [7:0]  rx_data = 0;
    logic        irq;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    uart_evt_regif dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic offer(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1; rx_data = b;
        @(negedge clk);
        rx_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 reset read", v, (a == 2) ? 32'h1 : 32'h0);
        end
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 tx_valid", {31'b0, tx_valid}, 0);
        chk("R1 rx_ready", {31'b0, rx_ready}, 1);

        // R2 walking ones and zeros on storage registers
        for (int a = 1; a < 5; a++) begin
            if (a == 2) continue;
            for (int b = 0; b < 32; b++) begin
                wr(3'(a), 32'h1 << b);
                rd(3'(a), v);
                chk("R2 walk1", v, 32'h1 << b);
                wr(3'(a), ~(32'h1 << b));
                rd(3'(a), v);
                chk("R2 walk0", v, ~(32'h1 << b));
            end
        end
        wr(3'd3, 0);

        // R3 / R4 transmit hold and replace
        wr(3'd2, 32'h6);
        tx_ready = 0;
        wr(3'd0, 32'hFFFF_01A5);
        chk("R3 tx_valid", {31'b0, tx_valid}, 1);
        chk("R3 tx_data", {24'b0, tx_data}, 32'hA5);
        rd(3'd2, v);
        chk("R4 txhit", v, 32'h5);
        repeat (3) @(negedge clk);
        chk("R3 hold valid", {31'b0, tx_valid}, 1);
        chk("R3 hold data", {24'b0, tx_data}, 32'hA5);
        wr(3'd0, 32'h3C);
        chk("R3 replace", {24'b0, tx_data}, 32'h3C);
        tx_ready = 1;
        @(negedge clk);
        chk("R3 drained", {31'b0, tx_valid}, 0);

        // R5 / R6 / R8 receive
        wr(3'd2, 32'h6);
        offer(8'h5E);
        chk("R5 rx_ready low", {31'b0, rx_ready}, 0);
        rd(3'd0, v);
        chk("R5 rx byte", v, 32'h5E);
        rd(3'd2, v);
        chk("R5 rxhit", v, 32'h3);
        offer(8'hC1);
        rd(3'd0, v);
        chk("R6 byte kept", v, 32'h5E);
        rd(3'd0, v);
        chk("R8 read no clear", {31'b0, rx_ready}, 0);
        rd(3'd2, v);
        chk("R8 flag kept", v, 32'h3);

        // R7 clear masks
        wr(3'd0, 32'h11);
        for (int m = 0; m < 8; m++) begin
            wr(3'd2, 32'h6);
            offer(8'h22);
            wr(3'd0, 32'h33);
            wr(3'd2, 32'hFFFF_FFF8 | 32'(m) | ((m == 7) ? 32'h0 : 32'h0));
            rd(3'd2, v);
            chk("R7 clear mask", v, 32'h1 | (((m >> 1) & 1) ? 0 : 2) | (((m >> 2) & 1) ? 0 : 4));
        end

        // R9 irq sweep
        for (int c = 0; c < 16; c++) begin
            wr(3'd2, 32'h6);
            wr(3'd3, 32'(c >> 2));
            if (c[0]) offer(8'h40 + 8'(c));
            if (c[1]) wr(3'd0, 32'(c));
            chk("R9 irq", {31'b0, irq},
                ((c[0] && c[2]) || (c[1] && c[3])) ? 1 : 0);
            rd(3'd2, v);
            chk("R9 flags", v, 32'h1 | (c[0] ? 2 : 0) | (c[1] ? 4 : 0));
        end
        wr(3'd3, 32'h3);
        wr(3'd2, 32'h6);
        chk("R9 irq after clear", {31'b0, irq}, 0);

        // R10 out of range
        wr(3'd1, 32'h1234_5678);
        wr(3'd3, 32'h0000_0004);
        wr(3'd4, 32'h0000_0001);
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 32'hFFFF_FFFF);
            rd(3'(a), v);
            chk("R10 read zero", v, 0);
        end
        rd(3'd1, v); chk("R10 baud kept", v, 32'h1234_5678);
        rd(3'd3, v); chk("R10 cfg kept", v, 32'h4);
        rd(3'd4, v); chk("R10 diag kept", v, 32'h1);
        rd(3'd2, v); chk("R10 flags kept", v, 32'h1);
        chk("R10 tx idle", {31'b0, tx_valid}, 0);

        // R11 idle read data
        @(negedge clk);
        bus_sel = 0; bus_addr = 3'd1;
        #1 chk("R11 idle rdata", bus_rdata, 0);
        bus_sel = 1; bus_wr = 1; bus_wdata = 32'h1234_5678;
        #1 chk("R11 write rdata", bus_rdata, 0);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule